// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates a group of related clock outputs for power management. It serves two stop sources. The first is an active-low power-down pin, which stops everything. The second is a software run bit, which stops only the outputs marked as stoppable. Each single-ended output can stop or restart only while its source clock is low. As a result, no output ever shows a pulse shorter than the source's own high phase.

The differential CPU pair works differently. Its true side parks during a high phase and is then held high. The complement side is held low and its driver is released. A register bit can instead release both drivers.

The source clocks arrive as level signals that are synchronous to a fast core clock `clk`. The gated outputs follow them. Before it is qualified, the power-down pin passes through a two-flop synchroniser. Power-down is recognised only after two consecutive rising edges of the complement CPU source have both seen the pin low. Release takes effect on the first synchronised high sample.

Top module: `clkstop_ctrl`

## Requirements
- R1: With no stop condition, every enabled single-ended output equals its source clock. `cpu_t_o` and `cpu_c_o` equal their sources, and `cpu_t_oe_o` and `cpu_c_oe_o` are both 1.
- R2: Power-down is entered only after the synchronised `pd_n_i` is seen low at two consecutive rising edges of `cpu_c_src_i`. A low pulse on `pd_n_i` of two core cycles covers only one such edge and has no effect on any output.
- R3: In power-down, every single-ended output goes low and stays low. An output may only fall together with its source, so its last high pulse is never truncated.
- R4: In power-down with `cpu_tri_i`=0, the following hold:
  - `cpu_t_o` is parked at 1 and `cpu_t_oe_o` is 1.
  - `cpu_c_oe_o` is 0 and `cpu_c_o` is 0.
  - The true output is never low while its source is high.
- R5: In power-down with `cpu_tri_i`=1, both `cpu_t_oe_o` and `cpu_c_oe_o` are 0.
- R6: With `sw_run_i`=0, each output whose `se_stop_mask_i` bit is 1 goes low. Outputs with a mask bit of 0 keep following their sources.
- R7: After a stop condition is removed, an output restarts only on a rising edge of its source. Its first pulse is therefore a full high phase.
- R8: An output whose `se_en_i` bit is 0 stays low whatever the run bit is. With `cpu_en_i`=0, both CPU output enables are 0.
- R9: Power-down ends on the first synchronised high sample of `pd_n_i`. After that, all outputs and both CPU output enables return to their R1 behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all sources change synchronously to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n_i | input | 1 | Asynchronous active-low power-down request |
| sw_run_i | input | 1 | Software run bit: 0 stops the stoppable outputs, 1 runs them |
| cpu_tri_i | input | 1 | CPU pair power-down mode: 0 park with the true side driven, 1 release both |
| cpu_en_i | input | 1 | CPU pair enable |
| cpu_t_src_i | input | 1 | CPU true source clock |
| cpu_c_src_i | input | 1 | CPU complement source clock |
| se_src_i | input | N_SE | Single-ended source clocks |
| se_en_i | input | N_SE | Per-output enable |
| se_stop_mask_i | input | N_SE | Per-output stoppable mask (1 = obeys the run bit) |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| cpu_t_o | output | 1 | Gated CPU true clock |
| cpu_c_o | output | 1 | Gated CPU complement clock |
| cpu_t_oe_o | output | 1 | CPU true driver enable |
| cpu_c_oe_o | output | 1 | CPU complement driver enable |

## Verification
A run flag that updates at the wrong phase shows at the ports. The output then rises in the middle of a source high phase, or falls while the source is still high, and the cycle monitor sees this on the very next sample. A qualifier that counts edges wrongly shows in one of two ways. Either a two-cycle low pulse stops the outputs, or a long low fails to stop them. Both are visible within a few source periods. Wrong CPU park logic shows as a true output that is low while its source is high, or as enable levels that differ from R4, R5 and R8 during the power-down window.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic {PARK_LOW = 1'b0, PARK_HIGH = 1'b1} park_e;
  localparam int unsigned DEF_QUAL_EDGES = 2;
  localparam int unsigned DEF_N_SE = 4;
endpackage

// File: rtl/clkstop_pd_qual.sv
module clkstop_pd_qual
  import clkstop_pkg::*;
#(
  parameter int unsigned QUAL_EDGES = DEF_QUAL_EDGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n_i,
  input  logic cpu_c_i,
  output logic pd_act_o
);
  localparam int unsigned CW = $clog2(QUAL_EDGES + 1);

  logic          sync1, sync2, c_prev;
  logic [CW-1:0] low_cnt;
  logic          c_rise;

  assign c_rise = cpu_c_i & ~c_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= 1'b1;
      sync2    <= 1'b1;
      c_prev   <= 1'b0;
      low_cnt  <= '0;
      pd_act_o <= 1'b0;
    end else begin
      sync1  <= pd_n_i;
      sync2  <= sync1;
      c_prev <= cpu_c_i;
      if (sync2) begin
        low_cnt  <= '0;
        pd_act_o <= 1'b0;
      end else if (c_rise) begin
        if (low_cnt == CW'(QUAL_EDGES - 1)) pd_act_o <= 1'b1;
        else low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  // R2: entry only after the synchronised pin was low
  p_entry_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_act_o) |-> !$past(sync2));

  // R9: first high sample ends power-down
  p_release_first_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync2 |=> !pd_act_o);
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter park_e PARK = PARK_LOW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic stop_i,
  output logic out_o,
  output logic run_o
);
  // The run flag moves only while the source sits at the park level,
  // so the output never changes level between source edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_o <= 1'b1;
    else if (src_i == logic'(PARK)) run_o <= ~stop_i;
  end

  generate
    if (PARK == PARK_HIGH) begin : g_park_high
      assign out_o = src_i | ~run_o;
    end else begin : g_park_low
      assign out_o = src_i & run_o;
    end
  endgenerate

  // R3, R7: the output changes only together with its source
  p_edge_with_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_o) |-> !$stable(src_i));

  // R7: a held output stays at the park level while the flag is clear
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && $past(!run_o)) |-> $stable(out_o));
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned N_SE       = DEF_N_SE,
  parameter int unsigned QUAL_EDGES = DEF_QUAL_EDGES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_n_i,
  input  logic            sw_run_i,
  input  logic            cpu_tri_i,
  input  logic            cpu_en_i,
  input  logic            cpu_t_src_i,
  input  logic            cpu_c_src_i,
  input  logic [N_SE-1:0] se_src_i,
  input  logic [N_SE-1:0] se_en_i,
  input  logic [N_SE-1:0] se_stop_mask_i,
  output logic [N_SE-1:0] se_clk_o,
  output logic            cpu_t_o,
  output logic            cpu_c_o,
  output logic            cpu_t_oe_o,
  output logic            cpu_c_oe_o
);
  logic            pd_act;
  logic            cpu_run;
  logic [N_SE-1:0] se_run;
  logic [N_SE-1:0] se_stop;

  clkstop_pd_qual #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_n_i   (pd_n_i),
    .cpu_c_i  (cpu_c_src_i),
    .pd_act_o (pd_act)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N_SE; gi++) begin : g_se
      assign se_stop[gi] = pd_act | ~se_en_i[gi] | (se_stop_mask_i[gi] & ~sw_run_i);

      clkstop_gate #(.PARK(PARK_LOW)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (se_src_i[gi]),
        .stop_i (se_stop[gi]),
        .out_o  (se_clk_o[gi]),
        .run_o  (se_run[gi])
      );

      // R6, R8: a cleared run flag means a low output
      p_stopped_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !se_run[gi] |-> !se_clk_o[gi]);
    end
  endgenerate

  clkstop_gate #(.PARK(PARK_HIGH)) u_cpu (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (cpu_t_src_i),
    .stop_i (pd_act),
    .out_o  (cpu_t_o),
    .run_o  (cpu_run)
  );

  // The true side parks during a source high phase, when the complement is low.
  assign cpu_c_o    = cpu_run & cpu_c_src_i;
  assign cpu_t_oe_o = cpu_en_i & (cpu_run | ~cpu_tri_i);
  assign cpu_c_oe_o = cpu_en_i & cpu_run;

  // R4: whenever the complement driver is released while enabled, true is high
  p_park_true_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en_i && !cpu_c_oe_o) |-> cpu_t_o);
endmodule

// File: tb/clkstop_ctrl_test.sv
module clkstop_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1, sw_run = 1'b1, cpu_tri = 1'b0, cpu_en = 1'b1;
  logic cpu_t_src = 1'b0;
  logic [N-1:0] se_src = '0, se_en = '1, se_mask = 4'b0011;
  logic [N-1:0] se_clk;
  logic cpu_t, cpu_c, oe_t, oe_c;

  int n_checks = 0, n_fail = 0;
  bit mon_on = 0, done = 0;
  int cnt [N];

  clkstop_ctrl #(.N_SE(N)) uut (
    .clk(clk), .rst_n(rst_n), .pd_n_i(pd_n), .sw_run_i(sw_run),
    .cpu_tri_i(cpu_tri), .cpu_en_i(cpu_en), .cpu_t_src_i(cpu_t_src),
    .cpu_c_src_i(~cpu_t_src), .se_src_i(se_src), .se_en_i(se_en),
    .se_stop_mask_i(se_mask), .se_clk_o(se_clk), .cpu_t_o(cpu_t),
    .cpu_c_o(cpu_c), .cpu_t_oe_o(oe_t), .cpu_c_oe_o(oe_c)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Sources: CPU toggles each cycle, output i has a half period of i+2 cycles.
  initial begin
    for (int i = 0; i < N; i++) cnt[i] = 0;
    forever begin
      @(negedge clk);
      cpu_t_src <= ~cpu_t_src;
      for (int i = 0; i < N; i++) begin
        if (cnt[i] == i + 1) begin cnt[i] = 0; se_src[i] <= ~se_src[i]; end
        else cnt[i] = cnt[i] + 1;
      end
    end
  end

  // Per-cycle edge monitor for R3, R4, R7.
  initial begin
    logic [N-1:0] p_out, p_src;
    p_out = '0; p_src = '0;
    forever begin
      @(posedge clk); #2;
      if (mon_on) begin
        for (int i = 0; i < N; i++) begin
          n_checks++;
          if (se_clk[i] && !se_src[i]) begin
            n_fail++; $display("FAIL R3 out%0d high with source low: act=%b exp=0", i, se_clk[i]);
          end
          if (se_clk[i] && !p_out[i] && p_src[i]) begin
            n_fail++; $display("FAIL R7 out%0d restarted mid-phase: act=1 exp=0", i);
          end
          if (!se_clk[i] && p_out[i] && se_src[i]) begin
            n_fail++; $display("FAIL R3 out%0d truncated pulse: act=0 exp=1", i);
          end
        end
        n_checks++;
        if (cpu_t_src && !cpu_t) begin
          n_fail++; $display("FAIL R4 cpu true low while source high: act=%b exp=1", cpu_t);
        end
      end
      p_out = se_clk; p_src = se_src;
    end
  end

  // Over a window: outputs in fmask follow their source, outputs in lmask stay low.
  task automatic win(input int cyc, input logic [N-1:0] fmask, input logic [N-1:0] lmask,
                     input string req);
    for (int i = 0; i < N; i++) begin
      bit bad = 0; logic a = 0, e = 0;
      for (int k = 0; k < cyc; k++) begin
        @(posedge clk); #2;
        if (!bad && fmask[i] && se_clk[i] !== se_src[i]) begin bad = 1; a = se_clk[i]; e = se_src[i]; end
        if (!bad && lmask[i] && se_clk[i] !== 1'b0) begin bad = 1; a = se_clk[i]; e = 1'b0; end
      end
      n_checks++;
      if (bad) begin n_fail++; $display("FAIL %s out%0d act=%b exp=%b", req, i, a, e); end
    end
  endtask

  task automatic cpu_chk(input bit follow, input logic e_oet, input logic e_oec, input string req);
    @(posedge clk); #2;
    n_checks++;
    if (follow && (cpu_t !== cpu_t_src || cpu_c !== ~cpu_t_src)) begin
      n_fail++; $display("FAIL %s cpu pair act=%b%b exp=%b%b", req, cpu_t, cpu_c, cpu_t_src, ~cpu_t_src);
    end
    if (!follow && (cpu_t !== 1'b1 || cpu_c !== 1'b0)) begin
      n_fail++; $display("FAIL %s cpu park act=%b%b exp=10", req, cpu_t, cpu_c);
    end
    n_checks++;
    if (oe_t !== e_oet || oe_c !== e_oec) begin
      n_fail++; $display("FAIL %s cpu oe act=%b%b exp=%b%b", req, oe_t, oe_c, e_oet, e_oec);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);
    mon_on = 1;
    // R1: reset state, pass-through
    cpu_chk(1, 1'b1, 1'b1, "R1");
    win(24, 4'b1111, 4'b0000, "R1");
    // R6: software stop of masked outputs only
    @(negedge clk) sw_run = 1'b0;
    wait_cyc(14);
    win(24, 4'b1100, 4'b0011, "R6");
    // R7: resume
    @(negedge clk) sw_run = 1'b1;
    wait_cyc(14);
    win(24, 4'b1111, 4'b0000, "R7");
    // R8: disabled output stays low with the run bit set
    @(negedge clk) se_en = 4'b0111;
    wait_cyc(14);
    win(24, 4'b0111, 4'b1000, "R8");
    @(negedge clk) se_en = 4'b1111;
    wait_cyc(14);
    // R2: two-cycle low pulse is ignored
    @(negedge clk) pd_n = 1'b0;
    @(negedge clk);
    @(negedge clk) pd_n = 1'b1;
    win(30, 4'b1111, 4'b0000, "R2");
    cpu_chk(1, 1'b1, 1'b1, "R2");
    // R3, R4: long power-down
    @(negedge clk) pd_n = 1'b0;
    wait_cyc(20);
    win(24, 4'b0000, 4'b1111, "R3");
    cpu_chk(0, 1'b1, 1'b0, "R4");
    // R5: three-state mode
    @(negedge clk) cpu_tri = 1'b1;
    cpu_chk(0, 1'b0, 1'b0, "R5");
    @(negedge clk) cpu_tri = 1'b0;
    // R9: release
    @(negedge clk) pd_n = 1'b1;
    wait_cyc(16);
    win(24, 4'b1111, 4'b0000, "R9");
    cpu_chk(1, 1'b1, 1'b1, "R9");
    // R8: CPU pair disable
    @(negedge clk) cpu_en = 1'b0;
    cpu_chk(1, 1'b0, 1'b0, "R8");
    @(negedge clk) cpu_en = 1'b1;
    cpu_chk(1, 1'b1, 1'b1, "R8");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      summary();
      $finish;
    end
  end
endmodule